// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Channel for a Drive Port

This block is one DMA channel for a disk drive port. The host sets it up through a byte-addressed register window. It loads the address of a descriptor table, picks a direction and sets the start bit. After that the channel works with no further help from the host. It reads two-word descriptors from memory. Each descriptor gives the address and byte count of one buffer region. For each region the channel moves data between memory and the drive's 16-bit word stream. It stops after the descriptor that carries the end-of-table flag.

Memory traffic uses a single request/acknowledge port that is 32 bits wide. Descriptor fetches and data beats both go through this port. Each 32-bit beat carries two drive words, and the low half always comes first. The channel reports three states through its status byte: busy, descriptor error and drive interrupt. A host interrupt line is asserted whenever the error or interrupt state is set.

Top module: `ide_busmaster_dma`

## Requirements
- R1: After reset:
  - the command byte (offset 0) reads 0x00;
  - the status byte (offset 2) reads 0x80, with bit 7 being the simplex-only constant, which is 1 by default;
  - the table pointer (offset 4) reads 0;
  - host_irq and mem_req are low.
- R2: The 32-bit table pointer at offset 4 always reads back with bits 1:0 equal to zero, whatever value was written.
- R3: When command bit 3 is 0 (memory to drive):
  - each region is read from memory in 4-byte beats at ascending addresses;
  - each beat is sent to the drive as two words, bits 15:0 first and then bits 31:16;
  - a region of N bytes yields N/2 words, so a trailing 2-byte remainder sends only the low half of its beat.
- R4: When command bit 3 is 1 (drive to memory):
  - pairs of drive words are packed low-first into 32-bit writes at ascending addresses, with byte enables 1111;
  - a trailing 2-byte remainder is written into the low half with byte enables 0011.
- R5: Descriptor layout and chaining:
  - word 0 of a descriptor is the buffer address;
  - word 1 holds the byte count in bits 15:0 and the end-of-table flag in bit 31;
  - descriptors are fetched from the pointer, then the pointer plus 8, and so on, until the flagged descriptor has been transferred.
- R6: A byte count field of 0 transfers 65536 bytes.
- R7: A descriptor with an odd byte count, or with address bits 1:0 not equal to zero, sets status bit 1. The channel then stops, clearing status bit 0, and moves no data.
- R8: When the flagged descriptor finishes:
  - if status bit 2 is already set, status bit 0 clears;
  - otherwise status bit 0 stays set until a drive interrupt arrives, and then it clears.
- R9: Status bits 1 and 2 are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R10: Writing 0 to command bit 0 during a transfer stops the channel at the next beat boundary. Status bit 0 clears and no further memory requests are issued.
- R11: Writes to command bit 3 are ignored while status bit 0 is set.
- R12: Drive interrupt and host interrupt:
  - a rising edge on drv_irq sets status bit 2 at the next clock;
  - a level held high does not set the bit again after it is cleared;
  - host_irq is the OR of status bits 1 and 2.
- R13: Status bit access:
  - bits 5 and 6 are plain read/write;
  - bit 7 is constant;
  - bits 3 and 4 read as zero;
  - bit 0 is read-only and shows whether the channel is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset (0 command, 2 status, 4 table pointer) |
| reg_wdata | input | 32 | Write data; byte registers use bits 7:0 |
| reg_rdata | output | 32 | Read data for the addressed register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Completes the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dout_valid | output | 1 | Word to drive is valid |
| dout_data | output | 16 | Word to drive |
| dout_ready | input | 1 | Drive accepts the word |
| din_valid | input | 1 | Word from drive is valid |
| din_data | input | 16 | Word from drive |
| din_ready | output | 1 | Channel accepts the word |
| drv_irq | input | 1 | Drive interrupt request |
| host_irq | output | 1 | Interrupt to host |

## Verification
A wrong remaining count or a wrong address register shows up at once at the ports. The word stream loses or repeats a half-word, or a memory beat goes to the wrong address, within the beat where the fault happens. A wrong descriptor decode shows up differently: the channel fetches the next descriptor at the wrong place, or it ends early, and this shows in the total number of words and in the busy bit when the run finishes. A wrong interrupt or error state is visible on host_irq one clock after its cause. The 64 KB case and the abort case are each run long enough that a miscount by a single beat would change the word total.

// File: rtl/ide_busmaster_dma.sv
module ide_busmaster_dma #(
  parameter bit SIMPLEX_ONLY = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        dout_valid,
  output logic [15:0] dout_data,
  input  logic        dout_ready,
  input  logic        din_valid,
  input  logic [15:0] din_data,
  output logic        din_ready,
  input  logic        drv_irq,
  output logic        host_irq
);

  typedef enum logic [3:0] {
    S_IDLE, S_FADDR, S_FCNT, S_NEXT, S_MRD, S_SLO, S_SHI,
    S_RLO, S_RHI, S_MWR, S_WAITI
  } state_t;

  state_t      state;
  logic        cmd_start, cmd_dir;
  logic        st_err, st_irq, irq_q;
  logic [1:0]  cap;
  logic [29:0] ptr;
  logic [31:0] desc_ptr, cur_addr, buf_q;
  logic [16:0] remain;
  logic        eot;

  wire busy     = (state != S_IDLE);
  wire wr_cmd   = reg_wr && (reg_addr == 3'd0);
  wire wr_st    = reg_wr && (reg_addr == 3'd2);
  wire wr_ptr   = reg_wr && (reg_addr == 3'd4);
  wire start_go = wr_cmd && reg_wdata[0] && !cmd_start && !busy;
  wire full     = remain > 17'd2;
  wire irq_rise = drv_irq && !irq_q;
  wire desc_bad = mem_rdata[0] || (cur_addr[1:0] != 2'b00);
  wire err_set  = (state == S_FCNT) && mem_ack && desc_bad;

  assign mem_req    = (state == S_FADDR) || (state == S_FCNT) || (state == S_MRD) || (state == S_MWR);
  assign mem_we     = (state == S_MWR);
  assign mem_addr   = (state == S_FADDR) ? desc_ptr :
                      (state == S_FCNT)  ? desc_ptr + 32'd4 : cur_addr;
  assign mem_be     = (state == S_MWR && !full) ? 4'b0011 : 4'b1111;
  assign mem_wdata  = buf_q;
  assign dout_valid = (state == S_SLO) || (state == S_SHI);
  assign dout_data  = (state == S_SHI) ? buf_q[31:16] : buf_q[15:0];
  assign din_ready  = (state == S_RLO) || (state == S_RHI);
  assign host_irq   = st_irq || st_err;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {24'd0, 4'd0, cmd_dir, 2'd0, cmd_start};
      3'd2:    reg_rdata = {24'd0, SIMPLEX_ONLY, cap, 2'd0, st_irq, st_err, busy};
      3'd4:    reg_rdata = {ptr, 2'b00};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_start <= 1'b0;
      cmd_dir   <= 1'b0;
      st_err    <= 1'b0;
      st_irq    <= 1'b0;
      irq_q     <= 1'b0;
      cap       <= 2'b00;
      ptr       <= '0;
    end else begin
      irq_q <= drv_irq;
      if (wr_cmd) begin
        cmd_start <= reg_wdata[0];
        if (!busy) cmd_dir <= reg_wdata[3];
      end
      if (wr_ptr) ptr <= reg_wdata[31:2];
      if (wr_st)  cap <= reg_wdata[6:5];
      if (irq_rise)                     st_irq <= 1'b1;
      else if (wr_st && reg_wdata[2])   st_irq <= 1'b0;
      if (err_set)                      st_err <= 1'b1;
      else if (wr_st && reg_wdata[1])   st_err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      desc_ptr <= '0;
      cur_addr <= '0;
      buf_q    <= '0;
      remain   <= '0;
      eot      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_go) begin
          desc_ptr <= {ptr, 2'b00};
          state    <= S_FADDR;
        end
        S_FADDR: if (mem_ack) begin
          cur_addr <= mem_rdata;
          state    <= S_FCNT;
        end
        S_FCNT: if (mem_ack) begin
          remain   <= {mem_rdata[15:0] == 16'd0, mem_rdata[15:0]};
          eot      <= mem_rdata[31];
          desc_ptr <= desc_ptr + 32'd8;
          state    <= desc_bad ? S_IDLE : S_NEXT;
        end
        S_NEXT: begin
          if (!cmd_start)          state <= S_IDLE;
          else if (remain == '0)   state <= !eot ? S_FADDR : (st_irq ? S_IDLE : S_WAITI);
          else                     state <= cmd_dir ? S_RLO : S_MRD;
        end
        S_MRD: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= S_SLO;
        end
        S_SLO: if (dout_ready) begin
          if (full) state <= S_SHI;
          else begin
            remain <= '0;
            state  <= S_NEXT;
          end
        end
        S_SHI: if (dout_ready) begin
          remain   <= remain - 17'd4;
          cur_addr <= cur_addr + 32'd4;
          state    <= S_NEXT;
        end
        S_RLO: if (din_valid) begin
          buf_q[15:0] <= din_data;
          state       <= full ? S_RHI : S_MWR;
        end
        S_RHI: if (din_valid) begin
          buf_q[31:16] <= din_data;
          state        <= S_MWR;
        end
        S_MWR: if (mem_ack) begin
          remain   <= full ? remain - 17'd4 : '0;
          cur_addr <= cur_addr + 32'd4;
          state    <= S_NEXT;
        end
        S_WAITI: if (st_irq || !cmd_start) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ide_busmaster_dma_chk.sv
module ide_busmaster_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        drv_irq,
  input logic        host_irq,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        dout_valid,
  input logic        dout_ready,
  input logic [15:0] dout_data,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        busy,
  input logic        cmd_dir,
  input logic        st_err
);

  a_r12_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> host_irq);

  a_r2_ptr_low: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4) |-> (reg_rdata[1:0] == 2'b00));

  a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r3_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

  a_r11_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_dir));

  a_r7_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err) |-> !busy);

  a_r4_be_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be == 4'b1111 || mem_be == 4'b0011));

endmodule

bind ide_busmaster_dma ide_busmaster_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .host_irq(host_irq),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .dout_valid(dout_valid), .dout_ready(dout_ready),
  .dout_data(dout_data), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .busy(busy), .cmd_dir(cmd_dir), .st_err(st_err)
);

// File: tb/test_ide_busmaster_dma.sv
module test_ide_busmaster_dma;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBL = 32'h100;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic dout_valid, dout_ready, din_valid, din_ready;
  logic [15:0] dout_data, din_data;
  logic drv_irq = 0, host_irq;
  logic throttle = 0;
  logic [31:0] tbl [16];
  int cyc = 0, din_cnt = 0, words = 0, bad = 0, extra = 0, reqs = 0;
  int total = 0, fails = 0;
  logic [15:0] exp_w[$];
  logic [31:0] wq_a[$], wq_d[$];
  logic [3:0]  wq_b[$];

  ide_busmaster_dma i_ide_busmaster_dma (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ {a[15:0], a[31:16]} ^ 32'h5A3C_C3A5;
  endfunction
  function automatic logic [15:0] dw(input int n);
    return 16'(n * 3 + 7);
  endfunction

  assign mem_ack    = mem_req;
  assign mem_rdata  = (mem_addr >= TBL && mem_addr < TBL + 32'd64) ? tbl[mem_addr[5:2]] : pat(mem_addr);
  assign dout_ready = ~throttle | cyc[0];
  assign din_valid  = 1'b1;
  assign din_data   = dw(din_cnt);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (din_valid && din_ready) din_cnt <= din_cnt + 1;
  end

  always @(negedge clk) begin
    if (mem_req) reqs++;
    if (dout_valid && dout_ready) begin
      words++;
      if (exp_w.size() == 0) extra++;
      else begin
        if (dout_data !== exp_w[0]) bad++;
        void'(exp_w.pop_front());
      end
    end
    if (mem_req && mem_we) begin
      wq_a.push_back(mem_addr); wq_d.push_back(mem_wdata); wq_b.push_back(mem_be);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse_irq();
    @(negedge clk); drv_irq = 1;
    @(negedge clk); drv_irq = 0;
  endtask

  task automatic run(input bit dir, input logic [31:0] p);
    wr(0, 0); wr(4, p);
    wr(0, {28'd0, dir, 3'd0});
    wr(0, {28'd0, dir, 3'd1});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 100000; i++) begin
      rd(2, v);
      if (!v[0]) break;
    end
  endtask

  task automatic push_region(input logic [31:0] base, input int cnt);
    for (int i = 0; i < cnt / 2; i++) begin
      logic [31:0] w;
      w = pat(base + 32'(i / 2) * 4);
      exp_w.push_back((i % 2) ? w[31:16] : w[15:0]);
    end
  endtask

  task automatic clr_stream();
    exp_w.delete(); words = 0; bad = 0; extra = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int d0, r0;
    for (int i = 0; i < 16; i++) tbl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    check(!mem_req && !host_irq, "R1", "req/irq low", {mem_req, host_irq}, 0);
    rd(0, v); check(v == 32'h00, "R1", "command", v, 32'h00);
    rd(2, v); check(v == 32'h80, "R1", "status", v, 32'h80);
    rd(4, v); check(v == 32'h0, "R1", "pointer", v, 32'h0);

    // R2 pointer low bits
    wr(4, 32'h0000_0103); rd(4, v);
    check(v == 32'h100, "R2", "pointer readback", v, 32'h100);

    // R3 R5 R8: drive-bound chain, end without interrupt pending
    tbl[0] = 32'h1000; tbl[1] = 32'h0000_0008;
    tbl[2] = 32'h2000; tbl[3] = 32'h8000_0006;
    clr_stream(); push_region(32'h1000, 8); push_region(32'h2000, 6);
    throttle = 1;
    run(0, TBL);
    for (int i = 0; i < 2000 && words < 7; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(words == 7 && bad == 0 && extra == 0, "R3", "chain word stream", words, 7);
    check(exp_w.size() == 0, "R5", "both descriptors consumed", exp_w.size(), 0);
    rd(2, v); check(v[0] == 1'b1, "R8", "busy held awaiting irq", v, 32'h81);
    pulse_irq(); repeat (3) @(negedge clk);
    rd(2, v); check(v[2:0] == 3'b100, "R8", "busy cleared by irq", v, 32'h84);
    wr(2, 32'h06); throttle = 0;

    // R4 memory-bound with 2-byte tail, irq preset
    tbl[4] = 32'h3000; tbl[5] = 32'h8000_000A;
    wq_a.delete(); wq_d.delete(); wq_b.delete();
    d0 = din_cnt;
    pulse_irq();
    run(1, TBL + 32'h10);
    wait_idle();
    check(wq_a.size() == 3, "R4", "write count", wq_a.size(), 3);
    if (wq_a.size() == 3) begin
      for (int k = 0; k < 2; k++) begin
        check(wq_a[k] == 32'h3000 + 32'(k) * 4 && wq_b[k] == 4'hF, "R4", "full beat addr/be",
              wq_a[k], 32'h3000 + 32'(k) * 4);
        check(wq_d[k] == {dw(d0 + 2*k + 1), dw(d0 + 2*k)}, "R4", "full beat data",
              wq_d[k], {dw(d0 + 2*k + 1), dw(d0 + 2*k)});
      end
      check(wq_a[2] == 32'h3008 && wq_b[2] == 4'h3 && wq_d[2][15:0] == dw(d0 + 4), "R4", "tail beat",
            wq_d[2], {16'h0, dw(d0 + 4)});
    end
    wr(2, 32'h06);

    // R6 zero count means 64 KB
    tbl[6] = 32'h10000; tbl[7] = 32'h8000_0000;
    clr_stream(); push_region(32'h10000, 65536);
    pulse_irq();
    run(0, TBL + 32'h18);
    wait_idle();
    check(words == 32768 && bad == 0 && extra == 0, "R6", "64K word count", words, 32768);
    wr(2, 32'h06);

    // R7 odd count
    tbl[8] = 32'h4000; tbl[9] = 32'h8000_0005;
    clr_stream();
    run(0, TBL + 32'h20);
    repeat (10) @(negedge clk);
    rd(2, v); check(v[2:0] == 3'b010 && host_irq && words == 0, "R7", "odd count error", v, 32'h82);
    // R9 write-one-to-clear of error
    wr(2, 32'h00); rd(2, v); check(v[1] == 1'b1, "R9", "write 0 keeps error", v, 32'h82);
    wr(2, 32'h02); rd(2, v); check(v[2:0] == 3'b000 && !host_irq, "R9", "write 1 clears error", v, 32'h80);

    // R7 misaligned address
    tbl[10] = 32'h4002; tbl[11] = 32'h8000_0008;
    run(0, TBL + 32'h28);
    repeat (10) @(negedge clk);
    rd(2, v); check(v[2:0] == 3'b010 && words == 0, "R7", "misaligned error", v, 32'h82);
    wr(2, 32'h06);

    // R10 R11 abort and frozen direction
    tbl[12] = 32'h20000; tbl[13] = 32'h8000_0000;
    clr_stream();
    run(0, TBL + 32'h30);
    repeat (30) @(negedge clk);
    wr(0, 32'h09);
    rd(0, v); check(v[3] == 1'b0, "R11", "direction write ignored while busy", v, 32'h01);
    repeat (10) @(negedge clk);
    wr(0, 32'h00);
    repeat (6) @(negedge clk);
    rd(2, v); check(v[0] == 1'b0, "R10", "abort clears busy", v, 32'h80);
    r0 = reqs;
    repeat (20) @(negedge clk);
    check(reqs == r0 && words > 0 && words < 32768, "R10", "no requests after abort", reqs - r0, 0);

    // R12 R9 interrupt edge and clearing
    pulse_irq(); @(negedge clk);
    rd(2, v); check(v[2] && host_irq, "R12", "rise sets irq", v, 32'h84);
    wr(2, 32'h00); rd(2, v); check(v[2] == 1'b1, "R9", "write 0 keeps irq", v, 32'h84);
    @(negedge clk); drv_irq = 1; repeat (2) @(negedge clk);
    wr(2, 32'h04); repeat (3) @(negedge clk);
    rd(2, v); check(v[2] == 1'b0 && !host_irq, "R12", "held level does not re-set", v, 32'h80);
    drv_irq = 0;

    // R13 status bit access
    wr(2, 32'hFF); rd(2, v); check(v == 32'hE0, "R13", "status after 0xFF", v, 32'hE0);
    wr(2, 32'h00); rd(2, v); check(v == 32'h80, "R13", "status after 0x00", v, 32'h80);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule